// File: doc/BRIEF.md
# Microprogram Sequencer with Loop Counter

This block chooses the next micro-program-counter value for a microcoded machine on every clock edge. A sequencer opcode from the microword selects one of several actions. The counter can step to the next address or jump to an immediate target. It can also take a branch that depends on one ALU flag or on the loop counter reaching zero. A one-deep call and return passes through a single return register. A halt parks the counter at address zero until a start pulse arrives.

The block also owns the loop counter. The microword can load the counter from a constant field, count it down by one, or write it from the data bus. A zero-detect on the counter gives the L flag, which the branch logic can test. A separate request in the microword produces a registered one-cycle strobe that tells the macro-level program counter to advance. The microcode store and the ALU are outside this block. The ALU supplies the Z, N, C and O flags, and the surrounding datapath supplies the bus value.

Top module: `useq_ctrl`

## Requirements
- R1: While reset is held low, and after it is released, `upc`, `lc`, the return register, `halted` and `pc_inc` are all zero, so `l_flag` is 1. A RET executed first after reset goes to address 0.
- R2: While running, opcode 0 (step) and the spare codes 13 to 15 load `upc` with `upc`+1, taken modulo 2^AW, on the next edge.
- R3: While running, opcode 1 (jump) loads `upc` with `tgt`.
- R4: While running, opcode 2 (call) copies the present `upc` into the return register and loads `upc` with `tgt`.
- R5: While running, opcode 3 (return) loads `upc` from the return register.
- R6: Conditional opcodes branch to `tgt` when their condition holds and otherwise step by one. The opcodes and their conditions are: 5 when Z=0, 6 when Z=1, 7 when N=1, 8 when C=1, 9 when O=1, 10 when L=1, 11 when C=0, 12 when O=0.
- R7: While running, opcode 4 (halt) sets `upc` to 0 and raises `halted`. While `halted` is high, every input other than `start` is ignored. `upc`, `lc` and the return register hold their values, and `pc_inc` stays low.
- R8: A `start` pulse while halted clears `halted` on the next edge with `upc` left at 0. The opcode presented in that cycle is not executed.
- R9: While running, `lc_op` = 1 loads `lc` from `lc_const`, `lc_op` = 2 decrements `lc`, wrapping from 0 to all ones, and codes 0 and 3 leave it unchanged. `l_flag` is 1 exactly when `lc` is zero.
- R10: While running, `lc_wr` loads `lc` from `bus_d` and overrides any `lc_op` in the same cycle. `lc_err` is high, combinationally, exactly when `lc_wr` and a load or decrement are requested together.
- R11: `pc_inc` is high for the cycle after a cycle in which the block was running and `inc_req` was high, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Leaves the halted state |
| op | input | 4 | Sequencer opcode |
| tgt | input | AW | Branch, jump and call target |
| z | input | 1 | ALU zero flag |
| n | input | 1 | ALU negative flag |
| c | input | 1 | ALU carry flag |
| o | input | 1 | ALU overflow flag |
| lc_op | input | 2 | Loop counter action: 0 hold, 1 load, 2 decrement, 3 hold |
| lc_const | input | LW | Constant for loop counter load |
| lc_wr | input | 1 | Bus move into the loop counter |
| bus_d | input | LW | Bus data |
| inc_req | input | 1 | Macro program counter increment request |
| upc | output | AW | Micro program counter |
| lc | output | LW | Loop counter |
| l_flag | output | 1 | Loop counter is zero |
| halted | output | 1 | Sequencer is halted |
| pc_inc | output | 1 | Macro program counter increment strobe |
| lc_err | output | 1 | Bus write and counter action collided |

## Verification
The bench builds the block with AW = 4 and LW = 4. At that size the address space is sixteen entries, so wrap-around of both the micro-PC and the loop counter comes up after a few steps. It also lets the bench sweep every one of the sixteen opcodes against all sixteen Z/N/C/O combinations, with the loop counter at zero and at a non-zero value. Each halt in the sweep is followed by a start cycle, and each call is followed by a return. Expected values come from a small next-state model kept in the bench.

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int AW = 8,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    op,
  input  logic [AW-1:0] tgt,
  input  logic          z,
  input  logic          n,
  input  logic          c,
  input  logic          o,
  input  logic [1:0]    lc_op,
  input  logic [LW-1:0] lc_const,
  input  logic          lc_wr,
  input  logic [LW-1:0] bus_d,
  input  logic          inc_req,
  output logic [AW-1:0] upc,
  output logic [LW-1:0] lc,
  output logic          l_flag,
  output logic          halted,
  output logic          pc_inc,
  output logic          lc_err
);
  localparam logic [3:0] OP_JMP  = 4'd1;
  localparam logic [3:0] OP_CALL = 4'd2;
  localparam logic [3:0] OP_RET  = 4'd3;
  localparam logic [3:0] OP_HALT = 4'd4;
  localparam logic [3:0] OP_BNZ  = 4'd5;
  localparam logic [3:0] OP_BRZ  = 4'd6;
  localparam logic [3:0] OP_BRN  = 4'd7;
  localparam logic [3:0] OP_BRC  = 4'd8;
  localparam logic [3:0] OP_BRO  = 4'd9;
  localparam logic [3:0] OP_BLZ  = 4'd10;
  localparam logic [3:0] OP_BNC  = 4'd11;
  localparam logic [3:0] OP_BNO  = 4'd12;
  localparam logic [1:0] LC_LOAD = 2'd1;
  localparam logic [1:0] LC_DEC  = 2'd2;

  logic [AW-1:0] ret_q;
  logic [AW-1:0] upc_nx;
  logic          run;
  logic          take;

  assign run    = !halted;
  assign l_flag = (lc == '0);
  assign lc_err = run && lc_wr && (lc_op == LC_LOAD || lc_op == LC_DEC);

  always_comb begin
    case (op)
      OP_JMP, OP_CALL: take = 1'b1;
      OP_BNZ:          take = !z;
      OP_BRZ:          take = z;
      OP_BRN:          take = n;
      OP_BRC:          take = c;
      OP_BRO:          take = o;
      OP_BLZ:          take = l_flag;
      OP_BNC:          take = !c;
      OP_BNO:          take = !o;
      default:         take = 1'b0;
    endcase
  end

  assign upc_nx = (op == OP_RET)  ? ret_q :
                  (op == OP_HALT) ? '0    :
                  take            ? tgt   : upc + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upc    <= '0;
      ret_q  <= '0;
      lc     <= '0;
      halted <= 1'b0;
      pc_inc <= 1'b0;
    end else begin
      pc_inc <= run && inc_req;
      if (run) begin
        upc <= upc_nx;
        if (op == OP_CALL) ret_q <= upc;
        if (op == OP_HALT) halted <= 1'b1;
        if (lc_wr)                lc <= bus_d;
        else if (lc_op == LC_LOAD) lc <= lc_const;
        else if (lc_op == LC_DEC)  lc <= lc - 1'b1;
      end else if (start) begin
        halted <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter int AW = 8,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [3:0]    op,
  input logic [AW-1:0] tgt,
  input logic [1:0]    lc_op,
  input logic          lc_wr,
  input logic [LW-1:0] bus_d,
  input logic [AW-1:0] upc,
  input logic [LW-1:0] lc,
  input logic          l_flag,
  input logic          halted,
  input logic          pc_inc
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && op == 4'd0) |=> upc == $past(upc) + 1'b1);

  p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && (op == 4'd1 || op == 4'd2)) |=> upc == $past(tgt));

  p_halt_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && op == 4'd4) |=> (upc == '0 && halted));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(upc) && $stable(lc)));

  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && start) |=> (!halted && upc == '0));

  p_lc_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !lc_wr && lc_op == 2'd2 && lc == LW'(1)) |=> l_flag);

  p_bus_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && lc_wr) |=> lc == $past(bus_d));

  p_no_inc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !pc_inc);
endmodule

bind useq_ctrl useq_ctrl_chk #(.AW(AW), .LW(LW)) u_chk (.*);

// File: tb/test_useq_ctrl.sv
module test_useq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, start, z, n, c, o, lc_wr, inc_req;
  logic [3:0] op, tgt, lc_const, bus_d;
  logic [1:0] lc_op;
  logic [3:0] upc, lc;
  logic       l_flag, halted, pc_inc, lc_err;

  int n_chk = 0;
  int n_fail = 0;

  logic [3:0] e_upc, e_stk, e_lc;
  logic       e_halt, e_inc;

  always #10 clk = ~clk;

  useq_ctrl #(.AW(4), .LW(4)) i_useq_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .tgt(tgt),
    .z(z), .n(n), .c(c), .o(o), .lc_op(lc_op), .lc_const(lc_const),
    .lc_wr(lc_wr), .bus_d(bus_d), .inc_req(inc_req),
    .upc(upc), .lc(lc), .l_flag(l_flag), .halted(halted),
    .pc_inc(pc_inc), .lc_err(lc_err));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int k);
    if (k == 1) return "R3";
    if (k == 2) return "R4";
    if (k == 3) return "R5";
    if (k == 4) return "R7";
    if (k >= 5 && k <= 12) return "R6";
    return "R2";
  endfunction

  task automatic step(input logic [3:0] t_op, input logic [3:0] t_tgt, input logic [3:0] fl,
                      input logic [1:0] t_lcop, input logic [3:0] t_cnst, input logic t_wr,
                      input logic [3:0] t_bus, input logic t_inc, input logic t_start,
                      input string tag);
    logic tk;
    logic [3:0] n_upc, n_stk, n_lc;
    logic n_halt;
    op = t_op; tgt = t_tgt; {z, n, c, o} = fl; lc_op = t_lcop; lc_const = t_cnst;
    lc_wr = t_wr; bus_d = t_bus; inc_req = t_inc; start = t_start;
    #1;
    chk(tag, "lc_err", int'(lc_err), int'(!e_halt && t_wr && (t_lcop == 2'd1 || t_lcop == 2'd2)));
    n_upc = e_upc; n_stk = e_stk; n_lc = e_lc; n_halt = e_halt;
    if (!e_halt) begin
      case (t_op)
        4'd5:  tk = !fl[3];
        4'd6:  tk = fl[3];
        4'd7:  tk = fl[2];
        4'd8:  tk = fl[1];
        4'd9:  tk = fl[0];
        4'd10: tk = (e_lc == 4'd0);
        4'd11: tk = !fl[1];
        4'd12: tk = !fl[0];
        default: tk = 1'b0;
      endcase
      if (t_op == 4'd1) n_upc = t_tgt;
      else if (t_op == 4'd2) begin n_upc = t_tgt; n_stk = e_upc; end
      else if (t_op == 4'd3) n_upc = e_stk;
      else if (t_op == 4'd4) begin n_upc = 4'd0; n_halt = 1'b1; end
      else if (tk) n_upc = t_tgt;
      else n_upc = e_upc + 4'd1;
      if (t_wr) n_lc = t_bus;
      else if (t_lcop == 2'd1) n_lc = t_cnst;
      else if (t_lcop == 2'd2) n_lc = e_lc - 4'd1;
      e_inc = t_inc;
    end else begin
      if (t_start) n_halt = 1'b0;
      e_inc = 1'b0;
    end
    e_upc = n_upc; e_stk = n_stk; e_lc = n_lc; e_halt = n_halt;
    @(posedge clk); #1;
    chk(tag, "upc", int'(upc), int'(e_upc));
    chk(tag, "lc", int'(lc), int'(e_lc));
    chk(tag, "l_flag", int'(l_flag), int'(e_lc == 4'd0));
    chk(tag, "halted", int'(halted), int'(e_halt));
    chk(tag, "pc_inc", int'(pc_inc), int'(e_inc));
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 0; op = 0; tgt = 0; {z, n, c, o} = 4'd0;
    lc_op = 0; lc_const = 0; lc_wr = 0; bus_d = 0; inc_req = 0;
    e_upc = 0; e_stk = 0; e_lc = 0; e_halt = 0; e_inc = 0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "upc", int'(upc), 0);
    chk("R1", "lc", int'(lc), 0);
    chk("R1", "l_flag", int'(l_flag), 1);
    chk("R1", "halted", int'(halted), 0);
    chk("R1", "pc_inc", int'(pc_inc), 0);
    rst_n = 1'b1;
    step(4'd1, 4'd7, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(4'd3, 4'd9, 0, 0, 0, 0, 0, 0, 0, "R1");

    step(4'd1, 4'd15, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(4'd0, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(4'd14, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R2");

    step(4'd0, 0, 0, 2'd2, 0, 0, 0, 0, 0, "R9");
    step(4'd0, 0, 0, 2'd3, 4'd5, 0, 0, 0, 0, "R9");
    step(4'd0, 0, 0, 2'd1, 4'd1, 0, 0, 0, 0, "R9");
    step(4'd0, 0, 0, 2'd2, 0, 0, 0, 0, 0, "R9");

    step(4'd0, 0, 0, 2'd2, 0, 1, 4'd9, 0, 0, "R10");
    step(4'd0, 0, 0, 2'd1, 4'd3, 1, 4'd6, 0, 0, "R10");
    step(4'd0, 0, 0, 2'd0, 0, 1, 4'd0, 0, 0, "R10");

    step(4'd0, 0, 0, 0, 0, 0, 0, 1, 0, "R11");
    step(4'd0, 0, 0, 0, 0, 0, 0, 1, 0, "R11");
    step(4'd0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");

    step(4'd1, 4'd6, 0, 2'd1, 4'd4, 0, 0, 0, 0, "R3");
    step(4'd4, 4'd2, 0, 0, 0, 0, 0, 1, 0, "R7");
    step(4'd1, 4'd9, 4'hF, 2'd1, 4'd8, 0, 0, 1, 0, "R7");
    step(4'd2, 4'd5, 0, 2'd2, 0, 1, 4'd3, 1, 0, "R7");
    step(4'd0, 4'd5, 0, 2'd2, 0, 0, 0, 1, 0, "R7");
    step(4'd1, 4'd12, 0, 2'd2, 0, 0, 0, 0, 1, "R8");
    step(4'd0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");

    for (int k = 0; k < 16; k++) begin
      for (int f = 0; f < 16; f++) begin
        for (int lz = 0; lz < 2; lz++) begin
          step(4'd1, 4'd5, 0, 2'd1, (lz != 0) ? 4'd0 : 4'd5, 0, 0, 0, 0, "R3");
          step(4'(k), 4'd11, 4'(f), 0, 0, 0, 0, 0, 0, tag_of(k));
          if (k == 2) step(4'd3, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
          if (e_halt) step(4'd1, 4'd9, 0, 2'd1, 4'd7, 0, 0, 1, 1, "R8");
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule